// File: doc/BRIEF.md
# Host-Target Mailbox Register Block

This block is a small memory-mapped peripheral through which a test core exchanges requests and answers with a host. It holds two 64-bit mailbox registers: a request register that the core writes, and a reply register that the block (or the core) fills. The core reaches each register as two 32-bit halves over a simple single-cycle register bus with combinational read data.

Once the core has written both halves of the request register, the block splits the word into a device byte, a command byte and a 48-bit payload, then acts on it. It can report a test exit code as a one-cycle pulse, send a console character out on a valid/ready byte stream, or park a console read until a character comes in on the input stream. Every finished request leaves a reply word in the reply register: the request's top 16 bits over a zero-extended 48-bit answer. The request register is then cleared, which the core reads as the sign that the block has taken the request. Only one request is in flight at a time. Memory-based system call proxying is handled by a separate block.

Top module: `host_mailbox`

## Requirements
- R1: The reply register sits at byte offset 0x0 (bits 31:0) and 0x4 (bits 63:32). The request register sits at 0x8 (bits 31:0) and 0xC (bits 63:32). A read at any other address returns zero. Both registers read zero after reset.
- R2: A write to the request low half (0x8) is stored as {32'b0, data} only while the whole request register is zero. Otherwise it changes nothing, and it withdraws the permission for the next high-half write.
- R3: A permitted write to the request high half (0xC) ORs the data into bits 63:32 and launches the request on the same clock edge. Launching withdraws the permission, so a high-half write that no accepted low-half write came before is ignored.
- R4: A request word is decoded as device = bits 63:56, command = bits 55:48 and payload = bits 47:0. Every reply keeps the request's bits 63:48 in reply bits 63:48.
- R5: Device 1, command 1 (character out) raises `cout_valid_o` in the cycle after the launch, with `cout_data_o` = payload bits 7:0. Both are held, and the request register keeps its value, until `cout_ready_i` is high at a clock edge. On that edge the reply becomes {bits 63:48, 48'h100 | char} and the request register clears.
- R6: Device 1, command 0 (character in) saves the request's bits 63:48 as the pending-read tag and clears the request register. The reply register is left unchanged.
- R7: Each cycle with `cin_valid_i` high sets the reply to {pending tag, 48'h100 | `cin_data_i`} on that edge. This overwrites any earlier, unread reply. `cin_ready_o` is always 1. The tag is zero after reset.
- R8: Device 0, command 0 with payload bit 0 set pulses `exit_valid_o` for exactly one cycle, the cycle after the launch, with `exit_code_o` = payload bits 31:1 (zero means pass). The reply becomes {bits 63:48, 48'b0} and the request register clears.
- R9: Every other request (device 0 command 0 with payload bit 0 clear, an unknown command, an unknown device) emits nothing. The reply becomes {bits 63:48, 48'b0} and the request register clears.
- R10: A core write to reply offset 0x0 loads the reply register with {32'b0, data} and sets `fh_partial_o`. A write to 0x4 ORs the data into bits 63:32 and clears `fh_partial_o`.
- R11: When updates to the reply register coincide on one edge, a core write wins over a request reply, and a request reply wins over an incoming character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address within the block |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle as the read strobe |
| fh_partial_o | output | 1 | Reply register is between a low-half and a high-half core write |
| cout_valid_o | output | 1 | Outgoing console character valid |
| cout_ready_i | input | 1 | Consumer accepts the outgoing character |
| cout_data_o | output | 8 | Outgoing console character |
| cin_valid_i | input | 1 | Incoming console character valid |
| cin_data_i | input | 8 | Incoming console character |
| cin_ready_o | output | 1 | Always 1, no back-pressure on input |
| exit_valid_o | output | 1 | One-cycle test-exit report |
| exit_code_o | output | 31 | Exit code, valid with exit_valid_o |

## Verification
Register reads are combinational, so the bench samples read data in the same cycle as the strobe, shortly after driving it. A request launches on the edge that takes the high-half write. The exit pulse and the outgoing character are therefore visible in the cycle that follows. The reply appears after that edge for exit and other requests, and after the accepting handshake edge for character output. An incoming character lands in the reply one edge after its valid cycle. Inputs are driven at falling edges. The scoreboard monitor samples the output streams one time unit after each falling edge, which is exactly what the next rising edge will take, and register readbacks are made only after the edge that is due to update them.

// File: rtl/host_mailbox_pkg.sv
package host_mailbox_pkg;
  localparam int unsigned WORD_W     = 64;
  localparam int unsigned HALF_W     = 32;
  localparam int unsigned HALF_BYTES = 4;
  localparam int unsigned TAG_W      = 16;
  localparam int unsigned RESP_W     = 48;
  localparam int unsigned CHAR_W     = 8;
  localparam int unsigned EXIT_W     = 31;
  localparam int unsigned NSLOT      = 4;

  localparam int unsigned DEV_LSB = 56;
  localparam int unsigned CMD_LSB = 48;

  // bus slot indices
  localparam int unsigned SLOT_FH_LO = 0;
  localparam int unsigned SLOT_FH_HI = 1;
  localparam int unsigned SLOT_TH_LO = 2;
  localparam int unsigned SLOT_TH_HI = 3;

  localparam logic [7:0] DEV_SYS     = 8'd0;
  localparam logic [7:0] DEV_CON     = 8'd1;
  localparam logic [7:0] CMD_SYS_REQ = 8'd0;
  localparam logic [7:0] CMD_CON_GET = 8'd0;
  localparam logic [7:0] CMD_CON_PUT = 8'd1;

  typedef enum logic [1:0] {ACT_NONE, ACT_PUT, ACT_GET, ACT_EXIT} act_e;
  typedef enum logic {ST_IDLE, ST_PUT_WAIT} cmd_state_e;

  function automatic logic [RESP_W-1:0] char_resp(input logic [CHAR_W-1:0] ch);
    return {{(RESP_W-CHAR_W-1){1'b0}}, 1'b1, ch};
  endfunction

  function automatic logic [WORD_W-1:0] build_reply(input logic [TAG_W-1:0] tag,
                                                    input logic [RESP_W-1:0] resp);
    return {tag, resp};
  endfunction
endpackage

// File: rtl/hmb_bus_decode.sv
module hmb_bus_decode
  import host_mailbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned FH_OFF = 0,
  parameter int unsigned TH_OFF = 8
) (
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [WORD_W-1:0]   fh_i,
  input  logic [WORD_W-1:0]   th_i,
  output logic [NSLOT-1:0]    wr_stb_o,
  output logic [HALF_W-1:0]   rdata_o
);
  logic [NSLOT-1:0]             hit;
  logic [NSLOT-1:0][HALF_W-1:0] halves;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam int unsigned BASE = (i < 2) ? FH_OFF : TH_OFF;
    localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE + (i % 2) * HALF_BYTES);
    logic [WORD_W-1:0] src;
    assign src       = (i < 2) ? fh_i : th_i;
    assign hit[i]    = req_i && (addr_i == SLOT_ADDR);
    assign halves[i] = src[(i % 2) * HALF_W +: HALF_W];
  end

  assign wr_stb_o = hit & {NSLOT{we_i}};

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (hit[i] && !we_i) rdata_o = rdata_o | halves[i];
    end
  end
endmodule

// File: rtl/hmb_cmd_unit.sv
module hmb_cmd_unit
  import host_mailbox_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               th_lo_wr_i,
  input  logic               th_hi_wr_i,
  input  logic [HALF_W-1:0]  wdata_i,
  output logic [WORD_W-1:0]  tohost_o,
  output logic               cout_valid_o,
  input  logic               cout_ready_i,
  output logic [CHAR_W-1:0]  cout_data_o,
  output logic               exit_valid_o,
  output logic [EXIT_W-1:0]  exit_code_o,
  output logic               reply_valid_o,
  output logic [WORD_W-1:0]  reply_o,
  output logic [TAG_W-1:0]   pend_tag_o
);
  logic [WORD_W-1:0] tohost_q;
  logic              permit_q;
  cmd_state_e        state_q;
  logic              exit_q;
  logic [EXIT_W-1:0] exit_code_q;
  logic [TAG_W-1:0]  pend_q;

  logic [WORD_W-1:0] full_word;
  logic [7:0]        dev, cmd;
  logic              launch, put_fire;
  act_e              act;

  assign full_word = tohost_q | {wdata_i, {HALF_W{1'b0}}};
  assign dev       = full_word[DEV_LSB +: 8];
  assign cmd       = full_word[CMD_LSB +: 8];
  assign launch    = th_hi_wr_i && permit_q;
  assign put_fire  = (state_q == ST_PUT_WAIT) && cout_ready_i;

  always_comb begin
    act = ACT_NONE;
    if (dev == DEV_CON && cmd == CMD_CON_PUT)                     act = ACT_PUT;
    else if (dev == DEV_CON && cmd == CMD_CON_GET)                act = ACT_GET;
    else if (dev == DEV_SYS && cmd == CMD_SYS_REQ && full_word[0]) act = ACT_EXIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tohost_q    <= '0;
      permit_q    <= 1'b0;
      state_q     <= ST_IDLE;
      exit_q      <= 1'b0;
      exit_code_q <= '0;
      pend_q      <= '0;
    end else begin
      exit_q <= 1'b0;
      if (th_lo_wr_i) begin
        if (tohost_q == '0) begin
          tohost_q <= {{HALF_W{1'b0}}, wdata_i};
          permit_q <= 1'b1;
        end else begin
          permit_q <= 1'b0;
        end
      end
      if (launch) begin
        permit_q <= 1'b0;
        unique case (act)
          ACT_PUT: begin
            tohost_q <= full_word;
            state_q  <= ST_PUT_WAIT;
          end
          ACT_GET: begin
            pend_q   <= full_word[WORD_W-1 -: TAG_W];
            tohost_q <= '0;
          end
          ACT_EXIT: begin
            exit_q      <= 1'b1;
            exit_code_q <= full_word[EXIT_W:1];
            tohost_q    <= '0;
          end
          default: tohost_q <= '0;
        endcase
      end
      if (put_fire) begin
        tohost_q <= '0;
        state_q  <= ST_IDLE;
      end
    end
  end

  always_comb begin
    reply_valid_o = 1'b0;
    reply_o       = '0;
    if (put_fire) begin
      reply_valid_o = 1'b1;
      reply_o = build_reply(tohost_q[WORD_W-1 -: TAG_W], char_resp(tohost_q[CHAR_W-1:0]));
    end else if (launch && (act == ACT_EXIT || act == ACT_NONE)) begin
      reply_valid_o = 1'b1;
      reply_o = build_reply(full_word[WORD_W-1 -: TAG_W], '0);
    end
  end

  assign tohost_o     = tohost_q;
  assign cout_valid_o = (state_q == ST_PUT_WAIT);
  assign cout_data_o  = tohost_q[CHAR_W-1:0];
  assign exit_valid_o = exit_q;
  assign exit_code_o  = exit_code_q;
  assign pend_tag_o   = pend_q;
endmodule

// File: rtl/hmb_fromhost_reg.sv
module hmb_fromhost_reg
  import host_mailbox_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fh_lo_wr_i,
  input  logic               fh_hi_wr_i,
  input  logic [HALF_W-1:0]  wdata_i,
  input  logic               reply_valid_i,
  input  logic [WORD_W-1:0]  reply_i,
  input  logic               cin_valid_i,
  input  logic [CHAR_W-1:0]  cin_data_i,
  input  logic [TAG_W-1:0]   pend_tag_i,
  output logic [WORD_W-1:0]  fromhost_o,
  output logic               partial_o
);
  logic [WORD_W-1:0] fh_q;
  logic              partial_q;

  // core write > request reply > incoming character
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fh_q      <= '0;
      partial_q <= 1'b0;
    end else if (fh_lo_wr_i) begin
      fh_q      <= {{HALF_W{1'b0}}, wdata_i};
      partial_q <= 1'b1;
    end else if (fh_hi_wr_i) begin
      fh_q      <= fh_q | {wdata_i, {HALF_W{1'b0}}};
      partial_q <= 1'b0;
    end else if (reply_valid_i) begin
      fh_q <= reply_i;
    end else if (cin_valid_i) begin
      fh_q <= build_reply(pend_tag_i, char_resp(cin_data_i));
    end
  end

  assign fromhost_o = fh_q;
  assign partial_o  = partial_q;
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import host_mailbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned FH_OFF = 0,
  parameter int unsigned TH_OFF = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              fh_partial_o,
  output logic              cout_valid_o,
  input  logic              cout_ready_i,
  output logic [7:0]        cout_data_o,
  input  logic              cin_valid_i,
  input  logic [7:0]        cin_data_i,
  output logic              cin_ready_o,
  output logic              exit_valid_o,
  output logic [30:0]       exit_code_o
);
  logic [NSLOT-1:0]  wr_stb;
  logic [WORD_W-1:0] fromhost_w, tohost_w, reply_w;
  logic              reply_valid_w;
  logic [TAG_W-1:0]  pend_tag_w;

  hmb_bus_decode #(.ADDR_W(ADDR_W), .FH_OFF(FH_OFF), .TH_OFF(TH_OFF)) u_dec (
    .req_i    (bus_req_i),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .fh_i     (fromhost_w),
    .th_i     (tohost_w),
    .wr_stb_o (wr_stb),
    .rdata_o  (bus_rdata_o)
  );

  hmb_cmd_unit u_cmd (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .th_lo_wr_i    (wr_stb[SLOT_TH_LO]),
    .th_hi_wr_i    (wr_stb[SLOT_TH_HI]),
    .wdata_i       (bus_wdata_i),
    .tohost_o      (tohost_w),
    .cout_valid_o  (cout_valid_o),
    .cout_ready_i  (cout_ready_i),
    .cout_data_o   (cout_data_o),
    .exit_valid_o  (exit_valid_o),
    .exit_code_o   (exit_code_o),
    .reply_valid_o (reply_valid_w),
    .reply_o       (reply_w),
    .pend_tag_o    (pend_tag_w)
  );

  hmb_fromhost_reg u_fh (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fh_lo_wr_i    (wr_stb[SLOT_FH_LO]),
    .fh_hi_wr_i    (wr_stb[SLOT_FH_HI]),
    .wdata_i       (bus_wdata_i),
    .reply_valid_i (reply_valid_w),
    .reply_i       (reply_w),
    .cin_valid_i   (cin_valid_i),
    .cin_data_i    (cin_data_i),
    .pend_tag_i    (pend_tag_w),
    .fromhost_o    (fromhost_w),
    .partial_o     (fh_partial_o)
  );

  assign cin_ready_o = 1'b1;
endmodule

// File: rtl/host_mailbox_chk.sv
module host_mailbox_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned FH_OFF = 0,
  parameter int unsigned TH_OFF = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       bus_rdata_o,
  input logic              fh_partial_o,
  input logic              cout_valid_o,
  input logic              cout_ready_i,
  input logic [7:0]        cout_data_o,
  input logic              exit_valid_o,
  input logic [63:0]       tohost_i,
  input logic [63:0]       fromhost_i
);
  localparam logic [ADDR_W-1:0] A_FH_LO = ADDR_W'(FH_OFF);
  localparam logic [ADDR_W-1:0] A_FH_HI = ADDR_W'(FH_OFF + 4);
  localparam logic [ADDR_W-1:0] A_TH_LO = ADDR_W'(TH_OFF);
  localparam logic [ADDR_W-1:0] A_TH_HI = ADDR_W'(TH_OFF + 4);

  logic wr, rd, known;
  assign wr    = bus_req_i && bus_we_i;
  assign rd    = bus_req_i && !bus_we_i;
  assign known = (bus_addr_i == A_FH_LO) || (bus_addr_i == A_FH_HI) ||
                 (bus_addr_i == A_TH_LO) || (bus_addr_i == A_TH_HI);

  assert_rd_unmapped_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && !known |-> bus_rdata_o == 32'h0);

  assert_th_lo_blocked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && bus_addr_i == A_TH_LO && tohost_i != 64'h0 && !(cout_valid_o && cout_ready_i)
    |=> $stable(tohost_i));

  assert_put_in_flight_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cout_valid_o |-> tohost_i[63:48] == 16'h0101);

  assert_put_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cout_valid_o && !cout_ready_i |=> cout_valid_o && $stable(cout_data_o));

  assert_put_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cout_valid_o && cout_ready_i |=> !cout_valid_o && tohost_i == 64'h0);

  assert_exit_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_valid_o |=> !exit_valid_o);

  assert_fh_lo_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && bus_addr_i == A_FH_LO |=> fh_partial_o && fromhost_i == {32'h0, $past(bus_wdata_i)});

  assert_fh_hi_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && bus_addr_i == A_FH_HI |=> !fh_partial_o && fromhost_i[63:32] == $past(fromhost_i[63:32] | bus_wdata_i));
endmodule

bind host_mailbox host_mailbox_chk #(.ADDR_W(ADDR_W), .FH_OFF(FH_OFF), .TH_OFF(TH_OFF)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_req_i    (bus_req_i),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .fh_partial_o (fh_partial_o),
  .cout_valid_o (cout_valid_o),
  .cout_ready_i (cout_ready_i),
  .cout_data_o  (cout_data_o),
  .exit_valid_o (exit_valid_o),
  .tohost_i     (tohost_w),
  .fromhost_i   (fromhost_w)
);

// File: tb/host_mailbox_tb_top.sv
`timescale 1ns/1ps
module host_mailbox_tb_top;
  localparam int unsigned ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_req = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              fh_partial, cout_valid, cout_ready = 1'b1, cin_ready, exit_valid;
  logic [7:0]        cout_data, cin_data = '0;
  logic              cin_valid = 1'b0;
  logic [30:0]       exit_code;

  int  checks = 0, failures = 0;
  bit  done = 1'b0;
  logic [7:0]  exp_chars[$];
  logic [30:0] exp_exits[$];

  always #10 clk = ~clk;

  host_mailbox #(.ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .fh_partial_o(fh_partial),
    .cout_valid_o(cout_valid), .cout_ready_i(cout_ready), .cout_data_o(cout_data),
    .cin_valid_i(cin_valid), .cin_data_i(cin_data), .cin_ready_o(cin_ready),
    .exit_valid_o(exit_valid), .exit_code_o(exit_code)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd_chk(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #2;
    chk(tag, 64'(bus_rdata), 64'(exp));
    bus_req = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] c);
    @(negedge clk);
    cin_valid = 1'b1; cin_data = c;
    @(negedge clk);
    cin_valid = 1'b0;
  endtask

  task automatic launch_req(input logic [31:0] lo, input logic [31:0] hi);
    bus_wr(6'h08, lo);
    bus_wr(6'h0C, hi);
  endtask

  task automatic chk_fh(input string tag, input logic [31:0] hi, input logic [31:0] lo);
    bus_rd_chk(tag, 6'h04, hi);
    bus_rd_chk(tag, 6'h00, lo);
  endtask

  // monitor: stream outputs sampled between edges, compared against scoreboard queues
  always begin
    @(negedge clk);
    #1;
    if (rst_n && cout_valid && cout_ready) begin
      checks++;
      if (exp_chars.size() == 0) begin
        failures++;
        $display("FAIL R5 unexpected char actual=%h expected=none", cout_data);
      end else begin
        logic [7:0] e;
        e = exp_chars.pop_front();
        if (cout_data !== e) begin
          failures++;
          $display("FAIL R5 char actual=%h expected=%h", cout_data, e);
        end
      end
    end
    if (rst_n && exit_valid) begin
      checks++;
      if (exp_exits.size() == 0) begin
        failures++;
        $display("FAIL R8 unexpected exit actual=%h expected=none", exit_code);
      end else begin
        logic [30:0] e;
        e = exp_exits.pop_front();
        if (exit_code !== e) begin
          failures++;
          $display("FAIL R8 exit code actual=%h expected=%h", exit_code, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and address map
    bus_rd_chk("R1 fh lo reset", 6'h00, 32'h0);
    bus_rd_chk("R1 fh hi reset", 6'h04, 32'h0);
    bus_rd_chk("R1 th lo reset", 6'h08, 32'h0);
    bus_rd_chk("R1 th hi reset", 6'h0C, 32'h0);
    chk("R1 outputs idle", {61'h0, cout_valid, exit_valid, fh_partial}, 64'h0);
    chk("R7 cin_ready", 64'(cin_ready), 64'h1);

    // R10 core writes to reply register
    bus_wr(6'h00, 32'h1122_3344);
    chk("R10 partial after lo", 64'(fh_partial), 64'h1);
    chk_fh("R10 lo load", 32'h0, 32'h1122_3344);
    bus_wr(6'h04, 32'hAABB_CCDD);
    chk("R10 partial after hi", 64'(fh_partial), 64'h0);
    chk_fh("R10 hi or", 32'hAABB_CCDD, 32'h1122_3344);
    bus_rd_chk("R1 unmapped 0x10", 6'h10, 32'h0);
    bus_rd_chk("R1 unaligned 0x2", 6'h02, 32'h0);

    // R5 character out, consumer ready
    exp_chars.push_back(8'h41);
    launch_req(32'h0000_0041, 32'h0101_0000);
    repeat (2) @(negedge clk);
    chk_fh("R5 put reply", 32'h0101_0000, 32'h0000_0141);
    bus_rd_chk("R5 th cleared", 6'h0C, 32'h0);

    // R5 stalled consumer, R2 blocked low write, R3 one in flight
    cout_ready = 1'b0;
    launch_req(32'h0000_005A, 32'h0101_1234);
    repeat (3) @(negedge clk);
    chk("R5 valid held", 64'(cout_valid), 64'h1);
    chk("R5 data held", 64'(cout_data), 64'h5A);
    bus_wr(6'h08, 32'h0000_0099);
    bus_wr(6'h0C, 32'h0700_0000);
    bus_rd_chk("R2 th lo kept", 6'h08, 32'h0000_005A);
    bus_rd_chk("R3 th hi kept", 6'h0C, 32'h0101_1234);
    chk_fh("R5 fh untouched while stalled", 32'h0101_0000, 32'h0000_0141);
    exp_chars.push_back(8'h5A);
    @(negedge clk);
    cout_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 valid dropped", 64'(cout_valid), 64'h0);
    chk_fh("R4 put reply tag", 32'h0101_0000, 32'h0000_015A);

    // R3 high write with no accepted low write is ignored
    bus_wr(6'h0C, 32'h0101_0000);
    repeat (2) @(negedge clk);
    bus_rd_chk("R3 bare hi ignored", 6'h0C, 32'h0);
    chk_fh("R3 fh unchanged", 32'h0101_0000, 32'h0000_015A);

    // R6 pending read, R7 character in
    launch_req(32'h0, 32'h0100_0000);
    bus_rd_chk("R6 th cleared", 6'h0C, 32'h0);
    chk_fh("R6 fh unchanged", 32'h0101_0000, 32'h0000_015A);
    send_char(8'h71);
    chk_fh("R7 char fills", 32'h0100_0000, 32'h0000_0171);
    send_char(8'h72);
    chk_fh("R7 overwrite", 32'h0100_0000, 32'h0000_0172);

    // R8 exit pass and fail
    exp_exits.push_back(31'h0);
    launch_req(32'h0000_0001, 32'h0);
    chk_fh("R8 exit reply", 32'h0, 32'h0);
    bus_rd_chk("R8 th cleared", 6'h08, 32'h0);
    exp_exits.push_back(31'h7FFF_FFFF);
    launch_req(32'hFFFF_FFFF, 32'h0);
    chk_fh("R8 exit fail reply", 32'h0, 32'h0);

    // R9 other requests, R4 tag kept
    launch_req(32'h0000_00AB, 32'h0700_0000);
    chk_fh("R4 R9 unknown device", 32'h0700_0000, 32'h0);
    bus_rd_chk("R9 th cleared", 6'h0C, 32'h0);
    launch_req(32'h0000_0041, 32'h0105_0000);
    chk_fh("R9 unknown command", 32'h0105_0000, 32'h0);
    launch_req(32'h0000_1000, 32'h0);
    chk_fh("R9 syscall form", 32'h0, 32'h0);

    // R11 core write beats incoming character
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 6'h00; bus_wdata = 32'h0000_BEEF;
    cin_valid = 1'b1; cin_data = 8'h55;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; cin_valid = 1'b0;
    chk_fh("R11 bus wins", 32'h0, 32'h0000_BEEF);
    bus_wr(6'h04, 32'h0);

    repeat (3) @(negedge clk);
    chk("R5 all chars seen", 64'(exp_chars.size()), 64'h0);
    chk("R8 all exits seen", 64'(exp_exits.size()), 64'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule